// File: doc/BRIEF.md
# Shared Pipelined CORDIC Engine

One deep CORDIC pipeline serves eight client cores. A free-running slot counter hands each client one issue cycle in every eight. In that cycle the client may start a rotation (magnitude and angle in, X and Y out) or a vectoring operation (X and Y in, magnitude and angle out). Every stage is its own register slice, so the engine takes a fresh operation on every clock. From a client's point of view it looks like a private unit that accepts one command per eight cycles.

Each operation carries a valid bit and the issuing client's tag down the pipe. When it leaves the last stage, its result is written into that client's own result queue. Issuing and collecting are separate handshakes, so a client can issue several commands in its successive slots and keep working while they are in flight. A client that tries to collect a result before one has arrived simply sees no valid result and stalls.

Angles are unsigned 32-bit fractions of a full turn (0x40000000 is a quarter turn) and may also be read as signed values. Operands and results are 32-bit two's complement.

Top module: `cordic_share`

## Requirements
- R1: A slot counter starts at 0 after reset and advances by one every clock, wrapping after client 7. cmd_ready[i] can be high only while the counter equals i, so at most one cmd_ready bit is set in any cycle. A command is taken on a rising edge where cmd_valid[i] and cmd_ready[i] are both high.
- R2: Rotation (cmd_op=0, cmd_a = signed magnitude m, cmd_b = angle a) returns res_x ≈ m·cos(a) and res_y ≈ m·sin(a), within 512 LSB, for angles in all four quadrants.
- R3: Vectoring (cmd_op=1, cmd_a = x, cmd_b = y) returns res_x ≈ sqrt(x²+y²) within 512 LSB, and res_y ≈ atan2(y,x) as a turn fraction within 4096 LSB, for inputs in all four quadrants.
- R4: If the client's queue is empty, res_valid[i] rises exactly STAGES (default 54) clock edges after the edge that accepted the command.
- R5: Until a result has arrived, res_valid[i] stays low, and holding res_ready[i] high consumes nothing.
- R6: Results for one client come back in the order the commands were issued, including when several are in flight at once.
- R7: A result appears only on the port of the client that issued it. Other clients' res_valid stays low.
- R8: The result port is valid/ready. While res_valid[i] is high and res_ready[i] is low, res_x and res_y hold steady, and a result is removed only on an edge where both are high. A client stops being offered slots (cmd_ready[i] held low) once DEPTH (default 8) of its results are in flight or queued but unread. Nothing is lost, and issuing resumes after a read.
- R9: While reset is held, every res_valid is low and cmd_ready equals 8'b0000_0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | NCLI | Per-client command request |
| cmd_ready | output | NCLI | Per-client issue slot open and queue space available |
| cmd_op | input | NCLI | Per-client operation: 0 rotate, 1 vector |
| cmd_a | input | NCLI×32 | Per-client magnitude (rotate) or x (vector) |
| cmd_b | input | NCLI×32 | Per-client angle (rotate) or y (vector) |
| res_valid | output | NCLI | Per-client result available |
| res_ready | input | NCLI | Per-client result taken |
| res_x | output | NCLI×32 | Per-client X (rotate) or magnitude (vector) |
| res_y | output | NCLI×32 | Per-client Y (rotate) or angle (vector) |

## Verification
The bench aims at the corners where a shared engine typically fails, and each has a visible symptom:

- **Quadrant fold.** Angles at and beyond a quarter turn, and vectors with negative x, test the fold. A wrong fold gives results with the wrong sign or mirrored.
- **Latency and routing.** The bench counts cycles to the first valid result and watches every other client's port. A miscounted pipe or a lost tag shows up as early or late data, or as data on the wrong port.
- **Queue credit.** One client fills its queue without reading, then leaves data unread for a while. A broken credit scheme either keeps offering slots and overflows, or drops and reorders results.
- **Concurrent issue.** All eight clients issue together. An error in slot sharing mixes up their answers.

// File: rtl/cordic_share_pkg.sv
package cordic_share_pkg;
  localparam int DW = 32;
  localparam int GW = 2;
  localparam int IW = DW + GW;
  localparam logic [DW-1:0] GAIN_Q = 32'd2608131496;
  localparam logic [DW-1:0] HALF_TURN = 32'h8000_0000;

  typedef enum logic {OP_ROTATE = 1'b0, OP_VECTOR = 1'b1} op_e;

  localparam int SL_FOLD  = 0;
  localparam int SL_MICRO = 1;
  localparam int SL_PASS  = 2;
  localparam int SL_GAIN  = 3;

  // arctangent of 2^-i as a fraction of a full turn
  function automatic logic [DW-1:0] atan_step(input int i);
    case (i)
      0:  atan_step = 32'h2000_0000;
      1:  atan_step = 32'h12E4_051E;
      2:  atan_step = 32'h09FB_385B;
      3:  atan_step = 32'h0511_11D4;
      4:  atan_step = 32'h028B_0D43;
      5:  atan_step = 32'h0145_D7E1;
      6:  atan_step = 32'h00A2_F61E;
      7:  atan_step = 32'h0051_7C55;
      8:  atan_step = 32'h0028_BE53;
      9:  atan_step = 32'h0014_5F2F;
      10: atan_step = 32'h000A_2F98;
      11: atan_step = 32'h0005_17CC;
      default: atan_step = DW'(64'd683565276 >> i);
    endcase
  endfunction
endpackage

// File: rtl/cordic_slice.sv
module cordic_slice
  import cordic_share_pkg::*;
#(
  parameter int TW   = 3,
  parameter int KIND = SL_PASS,
  parameter int SH   = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 i_v,
  input  logic [TW-1:0]        i_tag,
  input  logic                 i_op,
  input  logic signed [IW-1:0] i_x,
  input  logic signed [IW-1:0] i_y,
  input  logic [DW-1:0]        i_z,
  output logic                 o_v,
  output logic [TW-1:0]        o_tag,
  output logic                 o_op,
  output logic signed [IW-1:0] o_x,
  output logic signed [IW-1:0] o_y,
  output logic [DW-1:0]        o_z
);
  localparam int PW = IW + DW + 1;

  logic signed [IW-1:0] nx, ny;
  logic [DW-1:0]        nz;
  logic signed [PW-1:0] px, py;
  logic signed [IW-1:0] xs, ys;
  logic                 dpos;

  always_comb begin
    nx = i_x;
    ny = i_y;
    nz = i_z;
    xs = i_x >>> SH;
    ys = i_y >>> SH;
    dpos = (op_e'(i_op) == OP_VECTOR) ? i_y[IW-1] : !i_z[DW-1];
    px = PW'(i_x) * PW'($signed({1'b0, GAIN_Q}));
    py = PW'(i_y) * PW'($signed({1'b0, GAIN_Q}));
    if (KIND == SL_FOLD) begin
      if (op_e'(i_op) == OP_ROTATE) begin
        if (i_z[DW-1] ^ i_z[DW-2]) begin
          nx = -i_x;
          ny = -i_y;
          nz = i_z ^ HALF_TURN;
        end
      end else if (i_x[IW-1]) begin
        nx = -i_x;
        ny = -i_y;
        nz = HALF_TURN;
      end
    end else if (KIND == SL_MICRO) begin
      if (dpos) begin
        nx = i_x - ys;
        ny = i_y + xs;
        nz = i_z - atan_step(SH);
      end else begin
        nx = i_x + ys;
        ny = i_y - xs;
        nz = i_z + atan_step(SH);
      end
    end else if (KIND == SL_GAIN) begin
      nx = px[IW+DW-1:DW];
      ny = (op_e'(i_op) == OP_VECTOR) ? IW'(i_z) : py[IW+DW-1:DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_v   <= 1'b0;
      o_tag <= '0;
      o_op  <= 1'b0;
      o_x   <= '0;
      o_y   <= '0;
      o_z   <= '0;
    end else begin
      o_v   <= i_v;
      o_tag <= i_tag;
      o_op  <= i_op;
      o_x   <= nx;
      o_y   <= ny;
      o_z   <= nz;
    end
  end
endmodule

// File: rtl/cordic_pipe.sv
module cordic_pipe
  import cordic_share_pkg::*;
#(
  parameter int STAGES = 54,
  parameter int ITERS  = 28,
  parameter int TW     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_v,
  input  logic [TW-1:0]        in_tag,
  input  logic                 in_op,
  input  logic signed [IW-1:0] in_x,
  input  logic signed [IW-1:0] in_y,
  input  logic [DW-1:0]        in_z,
  output logic                 out_v,
  output logic [TW-1:0]        out_tag,
  output logic [DW-1:0]        out_x,
  output logic [DW-1:0]        out_y
);
  logic                 v_a   [STAGES+1];
  logic [TW-1:0]        tag_a [STAGES+1];
  logic                 op_a  [STAGES+1];
  logic signed [IW-1:0] x_a   [STAGES+1];
  logic signed [IW-1:0] y_a   [STAGES+1];
  logic [DW-1:0]        z_a   [STAGES+1];

  assign v_a[0]   = in_v;
  assign tag_a[0] = in_tag;
  assign op_a[0]  = in_op;
  assign x_a[0]   = in_x;
  assign y_a[0]   = in_y;
  assign z_a[0]   = in_z;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int KIND = (s == 0) ? SL_FOLD :
                          (s <= ITERS) ? SL_MICRO :
                          (s == STAGES-1) ? SL_GAIN : SL_PASS;
    cordic_slice #(.TW(TW), .KIND(KIND), .SH((s > 0) ? s-1 : 0)) u_slice (
      .clk(clk), .rst_n(rst_n),
      .i_v(v_a[s]), .i_tag(tag_a[s]), .i_op(op_a[s]),
      .i_x(x_a[s]), .i_y(y_a[s]), .i_z(z_a[s]),
      .o_v(v_a[s+1]), .o_tag(tag_a[s+1]), .o_op(op_a[s+1]),
      .o_x(x_a[s+1]), .o_y(y_a[s+1]), .o_z(z_a[s+1])
    );
  end

  assign out_v   = v_a[STAGES];
  assign out_tag = tag_a[STAGES];
  assign out_x   = x_a[STAGES][DW-1:0];
  assign out_y   = y_a[STAGES][DW-1:0];

  logic unused_tail;
  assign unused_tail = ^{x_a[STAGES][IW-1:DW], y_a[STAGES][IW-1:DW],
                         z_a[STAGES], op_a[STAGES]};

  // R4
  pipe_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (STAGES >= ITERS + 2));
endmodule

// File: rtl/result_fifo.sv
module result_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reserve,
  output logic          can_reserve,
  input  logic          wr,
  input  logic [DW-1:0] wx,
  input  logic [DW-1:0] wy,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rx,
  output logic [DW-1:0] ry
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_x [DEPTH];
  logic [DW-1:0] mem_y [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count, credit;
  logic          pop;

  assign pop         = rd_valid && rd_ready;
  assign rd_valid    = (count != '0);
  assign rx          = mem_x[rp];
  assign ry          = mem_y[rp];
  assign can_reserve = (credit < CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr) begin
      mem_x[wp] <= wx;
      mem_y[wp] <= wy;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp     <= '0;
      rp     <= '0;
      count  <= '0;
      credit <= '0;
    end else begin
      if (wr)  wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      count  <= count + CW'(wr) - CW'(pop);
      credit <= credit + CW'(reserve) - CW'(pop);
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> (count < CW'(DEPTH)));
  // R8
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rx) && $stable(ry)));
  // R8
  credit_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count <= credit));
  // R5
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !wr) |=> !rd_valid);
endmodule

// File: rtl/cordic_share.sv
module cordic_share
  import cordic_share_pkg::*;
#(
  parameter int NCLI   = 8,
  parameter int STAGES = 54,
  parameter int ITERS  = 28,
  parameter int DEPTH  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCLI-1:0]          cmd_valid,
  output logic [NCLI-1:0]          cmd_ready,
  input  logic [NCLI-1:0]          cmd_op,
  input  logic [NCLI-1:0][DW-1:0]  cmd_a,
  input  logic [NCLI-1:0][DW-1:0]  cmd_b,
  output logic [NCLI-1:0]          res_valid,
  input  logic [NCLI-1:0]          res_ready,
  output logic [NCLI-1:0][DW-1:0]  res_x,
  output logic [NCLI-1:0][DW-1:0]  res_y
);
  localparam int TW = $clog2(NCLI);

  logic [TW-1:0]        slot;
  logic [NCLI-1:0]      can_res;
  logic                 issue;
  logic signed [IW-1:0] in_x, in_y;
  logic [DW-1:0]        in_z;
  logic                 out_v;
  logic [TW-1:0]        out_tag;
  logic [DW-1:0]        out_x, out_y;

  always_ff @(posedge clk) begin
    if (!rst_n) slot <= '0;
    else        slot <= (slot == TW'(NCLI-1)) ? '0 : slot + 1'b1;
  end

  always_comb begin
    for (int i = 0; i < NCLI; i++)
      cmd_ready[i] = (slot == TW'(i)) && can_res[i];
  end

  assign issue = cmd_valid[slot] && cmd_ready[slot];
  assign in_x  = IW'($signed(cmd_a[slot]));
  assign in_y  = (op_e'(cmd_op[slot]) == OP_VECTOR) ? IW'($signed(cmd_b[slot])) : '0;
  assign in_z  = (op_e'(cmd_op[slot]) == OP_VECTOR) ? '0 : cmd_b[slot];

  cordic_pipe #(.STAGES(STAGES), .ITERS(ITERS), .TW(TW)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_v(issue), .in_tag(slot), .in_op(cmd_op[slot]),
    .in_x(in_x), .in_y(in_y), .in_z(in_z),
    .out_v(out_v), .out_tag(out_tag), .out_x(out_x), .out_y(out_y)
  );

  for (genvar i = 0; i < NCLI; i++) begin : g_cli
    result_fifo #(.DEPTH(DEPTH), .DW(DW)) u_q (
      .clk(clk), .rst_n(rst_n),
      .reserve(issue && (slot == TW'(i))),
      .can_reserve(can_res[i]),
      .wr(out_v && (out_tag == TW'(i))),
      .wx(out_x), .wy(out_y),
      .rd_valid(res_valid[i]), .rd_ready(res_ready[i]),
      .rx(res_x[i]), .ry(res_y[i])
    );

    // R1
    slot_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready[i] |=> !cmd_ready[i]);
  end

  // R1
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_ready));
  // R1
  slot_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != TW'(NCLI-1)) |=> (slot == $past(slot) + 1'b1));
endmodule

// File: tb/tb_cordic_share.sv
`timescale 1ns/1ps
module tb_cordic_share;
  localparam int N = 8;
  localparam int ST = 54;
  localparam int DEPTH = 8;
  localparam real TWO_PI = 6.283185307179586;
  localparam real TURN = 4294967296.0;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] cmd_valid, cmd_ready, cmd_op, res_valid, res_ready;
  logic [N-1:0][31:0] cmd_a, cmd_b, res_x, res_y;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  cordic_share dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_a(cmd_a), .cmd_b(cmd_b),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_x(res_x), .res_y(res_y)
  );

  task automatic note(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic near(string req, string what, logic [31:0] act, longint exp, int tol);
    logic [31:0] d;
    int sd;
    d = act - exp[31:0];
    sd = $signed(d);
    note(sd <= tol && sd >= -tol, req, what, longint'($signed(act)), exp);
  endtask

  function automatic logic [31:0] deg2ang(real d);
    longint li;
    li = longint'(d / 360.0 * TURN);
    return li[31:0];
  endfunction

  task automatic issue(int c, bit op, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    while (!cmd_ready[c]) @(negedge clk);
    cmd_valid[c] = 1'b1;
    cmd_op[c] = op;
    cmd_a[c] = a;
    cmd_b[c] = b;
    @(negedge clk);
    cmd_valid[c] = 1'b0;
  endtask

  task automatic get(int c, output logic [31:0] x, output logic [31:0] y);
    @(negedge clk);
    while (!res_valid[c]) @(negedge clk);
    x = res_x[c];
    y = res_y[c];
    res_ready[c] = 1'b1;
    @(negedge clk);
    res_ready[c] = 1'b0;
  endtask

  task automatic check_rot(string req, int c, logic [31:0] x, logic [31:0] y, int m, real deg);
    real th;
    th = deg / 360.0 * TWO_PI;
    near(req, $sformatf("rot x c%0d %0.1fdeg", c, deg), x, longint'(m * $cos(th)), 512);
    near(req, $sformatf("rot y c%0d %0.1fdeg", c, deg), y, longint'(m * $sin(th)), 512);
  endtask

  task automatic check_vec(string req, int c, logic [31:0] x, logic [31:0] y, int vx, int vy);
    real rx, ry;
    rx = vx;
    ry = vy;
    near(req, $sformatf("vec mag c%0d", c), x, longint'($sqrt(rx*rx + ry*ry)), 512);
    near(req, $sformatf("vec ang c%0d", c), y, longint'($atan2(ry, rx) / TWO_PI * TURN), 4096);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cmd_valid = '0; cmd_op = '0; cmd_a = '0; cmd_b = '0; res_ready = '0;
    repeat (3) @(negedge clk);
    note(res_valid == '0, "R9", "res_valid in reset", longint'(res_valid), 0);
    note(cmd_ready == 8'b0000_0001, "R9", "cmd_ready in reset", longint'(cmd_ready), 1);
    rst_n = 1'b1;
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      note(cmd_ready == 8'(1 << (k % 8)), "R1", $sformatf("slot walk k=%0d", k),
           longint'(cmd_ready), longint'(1 << (k % 8)));
    end
  endtask

  task automatic t_latency();
    logic [31:0] x, y;
    int seen;
    bit other;
    seen = -1;
    other = 1'b0;
    res_ready[2] = 1'b1;
    issue(2, 1'b0, 32'(1 << 28), 32'h0);
    for (int k = 1; k <= ST + 3; k++) begin
      @(negedge clk);
      if ((res_valid & ~8'b0000_0100) != '0) other = 1'b1;
      if (res_valid[2] && seen < 0) seen = k;
    end
    res_ready[2] = 1'b0;
    note(seen == ST, "R4", "latency edges", seen, ST);
    note(!other, "R7", "foreign res_valid during latency test", other, 0);
    issue(2, 1'b0, 32'(1 << 28), 32'h0);
    get(2, x, y);
    check_rot("R5", 2, x, y, 1 << 28, 0.0);
  endtask

  task automatic t_rotate();
    real degs[6] = '{30.0, 90.0, 135.0, 180.0, 225.0, 300.0};
    logic [31:0] x, y;
    for (int i = 0; i < 6; i++) begin
      issue(3, 1'b0, 32'(1 << 29), deg2ang(degs[i]));
      get(3, x, y);
      check_rot("R2", 3, x, y, 1 << 29, degs[i]);
    end
  endtask

  task automatic t_vector();
    int vx[5] = '{300000000, -300000000, -500000000, 200000000, 100000000};
    int vy[5] = '{400000000, 400000000, -100000000, -70000000, 0};
    logic [31:0] x, y;
    for (int i = 0; i < 5; i++) begin
      issue(6, 1'b1, 32'(vx[i]), 32'(vy[i]));
      get(6, x, y);
      check_vec("R3", 6, x, y, vx[i], vy[i]);
    end
  endtask

  task automatic t_order();
    real degs[3] = '{10.0, 200.0, 320.0};
    logic [31:0] x, y;
    for (int i = 0; i < 3; i++) issue(5, 1'b0, 32'(1 << 28), deg2ang(degs[i]));
    for (int i = 0; i < 3; i++) begin
      get(5, x, y);
      check_rot("R6", 5, x, y, 1 << 28, degs[i]);
    end
  endtask

  task automatic t_backpressure();
    logic [31:0] x, y, hx, hy;
    bit leak, held;
    leak = 1'b0;
    held = 1'b1;
    for (int i = 0; i < DEPTH; i++)
      issue(1, 1'b1, 32'(100000000 + i * 20000000), 32'(50000000 * (i - 3)));
    for (int k = 0; k < ST + 16; k++) begin
      @(negedge clk);
      if (cmd_ready[1]) leak = 1'b1;
    end
    note(!leak, "R8", "cmd_ready while queue full", leak, 0);
    hx = res_x[1];
    hy = res_y[1];
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (!res_valid[1] || res_x[1] != hx || res_y[1] != hy) held = 1'b0;
    end
    note(held, "R8", "result held without ready", held, 1);
    for (int i = 0; i < DEPTH; i++) begin
      get(1, x, y);
      check_vec("R8", 1, x, y, 100000000 + i * 20000000, 50000000 * (i - 3));
    end
    @(negedge clk);
    note(res_valid[1] == 1'b0, "R8", "queue drained", res_valid[1], 0);
    issue(1, 1'b0, 32'(1 << 27), deg2ang(45.0));
    get(1, x, y);
    check_rot("R8", 1, x, y, 1 << 27, 45.0);
  endtask

  task automatic t_all_clients();
    logic [31:0] xs[N], ys[N];
    for (int c = 0; c < N; c++) begin
      automatic int cc = c;
      fork
        issue(cc, 1'b0, 32'((1 << 28) + cc * 1000), deg2ang(cc * 45.0 + 10.0));
      join_none
    end
    wait fork;
    for (int c = 0; c < N; c++) get(c, xs[c], ys[c]);
    for (int c = 0; c < N; c++)
      check_rot("R7", c, xs[c], ys[c], (1 << 28) + c * 1000, c * 45.0 + 10.0);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_rotate();
    t_vector();
    t_order();
    t_backpressure();
    t_all_clients();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R4 watchdog actual=%0d expected=%0d", 100000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule